// File: doc/BRIEF.md
# Floating Register Miscellaneous Operate Unit

This unit carries out the non-arithmetic operations that act on 64-bit floating registers. It takes one operation per cycle. Each operation has an 11-bit function code, two source operands A and B, and the current contents of destination C. One clock later it presents the result, a destination write enable, an integer-overflow fault and an unimplemented-function flag.

It handles four groups of functions:
- Conversions between the longword layout held in a floating register and ordinary 32-bit or 64-bit integers. One of these conversions checks for overflow.
- Sign-transfer operations.
- Conditional moves that compare A with zero.
- Access to a 64-bit floating control register that the unit holds.

The unit does no rounding, no arithmetic and no IEEE exception handling. A pipeline drives it from its register-read stage and uses the write enable to commit the result.

Top module: `fp_misc_unit`

## Requirements
- R1: Function 0x010 forms a 32-bit value. Bits 31:30 of the value come from B[63:62] and bits 29:0 come from B[58:29]. The result is this value sign-extended to 64 bits, and the write enable is 1.
- R2: Function 0x030 returns a result in which B[31:30] sit at bits 63:62 and B[29:0] sit at bits 58:29. Every other result bit is 0. The write enable is 1.
- R3: Functions 0x130 and 0x530 give the same result as 0x030. They assert the overflow fault and drop the write enable whenever B[63:31] is neither all zeros nor all ones.
- R4: Function 0x020 returns {A[63], B[62:0]}. Function 0x021 returns {~A[63], B[62:0]}. Both set the write enable.
- R5: Function 0x022 returns {A[63:52], B[51:0]} and sets the write enable.
- R6: Functions 0x02a through 0x02f test A against zero for equal, not equal, less than, greater or equal, less or equal and greater than, in that order. A counts as zero when A[62:0] is 0, whatever A[63] is. A is negative when A[63] is 1 and it is nonzero. The result is B when the test holds and C when it does not, and the write enable is 1 in both cases.
- R7: Function 0x024 loads A into the control register and does not set the write enable. Function 0x025 returns the control register and sets the write enable. After reset the control register reads 0.
- R8: Any other function code sets the unimplemented flag, clears the write enable and returns a zero result.
- R9: The outputs for an accepted operation appear on the first clock edge after valid_i. In a cycle without valid_i, the next cycle shows the write enable and both flags at 0, and the result keeps its previous value.
- R10: While reset is active, the result, the write enable and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| func_i | input | 11 | Function code |
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B |
| op_c_i | input | 64 | Current destination value |
| result_o | output | 64 | Registered result |
| wr_en_o | output | 1 | Destination write enable |
| ovf_fault_o | output | 1 | Integer-overflow fault |
| unimpl_o | output | 1 | Unimplemented function code |

## Verification
The assertions assume three things about the inputs:
- valid_i is low throughout reset.
- Operand values carry no unknown bits whenever valid_i is high.
- The control register changes only through function 0x024.

The stimulus meets these assumptions. It holds valid_i low until after reset is released, and it drives every operand from $urandom or from fixed values. A fixed seed makes each run repeat exactly. Random function codes are drawn partly from the defined set and partly from the whole 11-bit space. Directed cases cover both signed zeros, the boundaries of the 33-bit overflow window, and a control-register write followed at once by a read.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned FUNC_W = 11;
  localparam int unsigned EXP_W  = 12;

  localparam logic [FUNC_W-1:0] F_CVT_LQ   = 11'h010;
  localparam logic [FUNC_W-1:0] F_CVT_QL   = 11'h030;
  localparam logic [FUNC_W-1:0] F_CVT_QLV  = 11'h130;
  localparam logic [FUNC_W-1:0] F_CVT_QLV2 = 11'h530;
  localparam logic [FUNC_W-1:0] F_CPYS     = 11'h020;
  localparam logic [FUNC_W-1:0] F_CPYSN    = 11'h021;
  localparam logic [FUNC_W-1:0] F_CPYSE    = 11'h022;
  localparam logic [FUNC_W-1:0] F_CTRL_WR  = 11'h024;
  localparam logic [FUNC_W-1:0] F_CTRL_RD  = 11'h025;
  localparam logic [FUNC_W-1:0] F_CMOV_EQ  = 11'h02a;
  localparam logic [FUNC_W-1:0] F_CMOV_GT  = 11'h02f;

  typedef enum logic [3:0] {
    OP_NONE, OP_CVT_LQ, OP_CVT_QL, OP_CVT_QLV,
    OP_SGN, OP_SGN_NEG, OP_SGN_EXP, OP_CMOV, OP_CTRL_WR, OP_CTRL_RD
  } op_e;

  typedef enum logic [2:0] {
    CND_EQ, CND_NE, CND_LT, CND_GE, CND_LE, CND_GT
  } cond_e;
endpackage

// File: rtl/fpm_decode.sv
module fpm_decode
  import fpm_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output op_e               op_o,
  output cond_e             cond_o
);
  always_comb begin
    op_o   = OP_NONE;
    cond_o = CND_EQ;
    unique case (func_i)
      F_CVT_LQ:               op_o = OP_CVT_LQ;
      F_CVT_QL:               op_o = OP_CVT_QL;
      F_CVT_QLV, F_CVT_QLV2:  op_o = OP_CVT_QLV;
      F_CPYS:                 op_o = OP_SGN;
      F_CPYSN:                op_o = OP_SGN_NEG;
      F_CPYSE:                op_o = OP_SGN_EXP;
      F_CTRL_WR:              op_o = OP_CTRL_WR;
      F_CTRL_RD:              op_o = OP_CTRL_RD;
      default: begin
        if (func_i >= F_CMOV_EQ && func_i <= F_CMOV_GT) begin
          op_o   = OP_CMOV;
          cond_o = cond_e'(func_i[2:0] - 3'd2);
        end
      end
    endcase
  end
endmodule

// File: rtl/fpm_convert.sv
module fpm_convert
  import fpm_pkg::*;
#(
  parameter int unsigned OVF_SPAN = 33
) (
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] lq_o,
  output logic [XLEN-1:0] ql_o,
  output logic            ovf_o
);
  localparam int unsigned HALF = XLEN / 2;
  logic [HALF-1:0]     lw;
  logic [OVF_SPAN-1:0] upper;

  // register longword layout: sign pair at top, 30-bit body below a 3-bit gap
  assign lw    = {b_i[63:62], b_i[58:29]};
  assign lq_o  = {{HALF{lw[HALF-1]}}, lw};
  assign ql_o  = {b_i[31:30], 3'b000, b_i[29:0], 29'd0};
  assign upper = b_i[XLEN-1 -: OVF_SPAN];
  assign ovf_o = (upper != '0) && (upper != '1);
endmodule

// File: rtl/fpm_sign.sv
module fpm_sign
  import fpm_pkg::*;
(
  input  op_e              op_i,
  input  logic [EXP_W-1:0] a_hi_i,
  input  logic [XLEN-1:0]  b_i,
  output logic [XLEN-1:0]  res_o
);
  always_comb begin
    unique case (op_i)
      OP_SGN_NEG: res_o = {~a_hi_i[EXP_W-1], b_i[XLEN-2:0]};
      OP_SGN_EXP: res_o = {a_hi_i, b_i[XLEN-EXP_W-1:0]};
      default:    res_o = {a_hi_i[EXP_W-1], b_i[XLEN-2:0]};
    endcase
  end
endmodule

// File: rtl/fpm_cmov.sv
module fpm_cmov
  import fpm_pkg::*;
(
  input  cond_e           cond_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] c_i,
  output logic [XLEN-1:0] res_o
);
  logic is_zero, is_neg, take;

  assign is_zero = (a_i[XLEN-2:0] == '0);
  assign is_neg  = a_i[XLEN-1] && !is_zero;

  always_comb begin
    unique case (cond_i)
      CND_EQ:  take = is_zero;
      CND_NE:  take = !is_zero;
      CND_LT:  take = is_neg;
      CND_GE:  take = !is_neg;
      CND_LE:  take = is_neg || is_zero;
      default: take = !is_neg && !is_zero;
    endcase
  end

  assign res_o = take ? b_i : c_i;
endmodule

// File: rtl/fp_misc_unit.sv
module fp_misc_unit
  import fpm_pkg::*;
#(
  parameter logic [XLEN-1:0] CTRL_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [XLEN-1:0]   op_a_i,
  input  logic [XLEN-1:0]   op_b_i,
  input  logic [XLEN-1:0]   op_c_i,
  output logic [XLEN-1:0]   result_o,
  output logic              wr_en_o,
  output logic              ovf_fault_o,
  output logic              unimpl_o
);
  op_e             op;
  cond_e           cond;
  logic [XLEN-1:0] lq_res, ql_res, sgn_res, cmov_res, res_d, ctrl_q;
  logic            ovf_raw, we_d, ovf_d, unimpl_d;

  fpm_decode u_decode (.func_i(func_i), .op_o(op), .cond_o(cond));

  fpm_convert #(.OVF_SPAN(XLEN/2 + 1)) u_convert (
    .b_i(op_b_i), .lq_o(lq_res), .ql_o(ql_res), .ovf_o(ovf_raw)
  );

  fpm_sign u_sign (
    .op_i(op), .a_hi_i(op_a_i[XLEN-1 -: EXP_W]), .b_i(op_b_i), .res_o(sgn_res)
  );

  fpm_cmov u_cmov (
    .cond_i(cond), .a_i(op_a_i), .b_i(op_b_i), .c_i(op_c_i), .res_o(cmov_res)
  );

  always_comb begin
    res_d    = '0;
    we_d     = 1'b1;
    ovf_d    = 1'b0;
    unimpl_d = 1'b0;
    unique case (op)
      OP_CVT_LQ:                     res_d = lq_res;
      OP_CVT_QL:                     res_d = ql_res;
      OP_CVT_QLV: begin
        res_d = ql_res;
        ovf_d = ovf_raw;
        we_d  = !ovf_raw;
      end
      OP_SGN, OP_SGN_NEG, OP_SGN_EXP: res_d = sgn_res;
      OP_CMOV:                       res_d = cmov_res;
      OP_CTRL_WR:                    we_d  = 1'b0;
      OP_CTRL_RD:                    res_d = ctrl_q;
      default: begin
        we_d     = 1'b0;
        unimpl_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      wr_en_o     <= 1'b0;
      ovf_fault_o <= 1'b0;
      unimpl_o    <= 1'b0;
    end else if (valid_i) begin
      result_o    <= res_d;
      wr_en_o     <= we_d;
      ovf_fault_o <= ovf_d;
      unimpl_o    <= unimpl_d;
    end else begin
      wr_en_o     <= 1'b0;
      ovf_fault_o <= 1'b0;
      unimpl_o    <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ctrl_q <= CTRL_RST;
    else if (valid_i && op == OP_CTRL_WR)  ctrl_q <= op_a_i;
  end

  p_no_overflow_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_fault_o |-> !wr_en_o);
  p_unimpl_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unimpl_o |-> (!wr_en_o && result_o == '0 && !ovf_fault_o));
  p_idle_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!wr_en_o && !ovf_fault_o && !unimpl_o));
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  p_ctrl_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && func_i == F_CTRL_WR) |=> (ctrl_q == $past(op_a_i)));
  p_ctrl_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && func_i == F_CTRL_WR) |=> $stable(ctrl_q));
  p_ovf_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_CVT_QLV &&
     (op_b_i[XLEN-1:XLEN/2-1] == '0 || op_b_i[XLEN-1:XLEN/2-1] == '1)) |=> !ovf_fault_o);
endmodule

// File: tb/fp_misc_unit_tb_top.sv
module fp_misc_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [10:0] func_i = '0;
  logic [63:0] op_a_i = '0, op_b_i = '0, op_c_i = '0;
  logic [63:0] result_o;
  logic        wr_en_o, ovf_fault_o, unimpl_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [63:0] ctrl_m = '0;
  logic [63:0] last_res = '0;

  typedef struct packed {
    logic [63:0] res;
    logic        we;
    logic        ovf;
    logic        unimpl;
  } exp_t;

  always #5 clk_i = ~clk_i;

  fp_misc_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .func_i(func_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .op_c_i(op_c_i), .result_o(result_o),
    .wr_en_o(wr_en_o), .ovf_fault_o(ovf_fault_o), .unimpl_o(unimpl_o)
  );

  function automatic string req_of(logic [10:0] f);
    case (f)
      11'h010: return "R1";
      11'h030: return "R2";
      11'h130, 11'h530: return "R3";
      11'h020, 11'h021: return "R4";
      11'h022: return "R5";
      11'h02a, 11'h02b, 11'h02c, 11'h02d, 11'h02e, 11'h02f: return "R6";
      11'h024, 11'h025: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic exp_t model(logic [10:0] f, logic [63:0] a, b, c, ctl);
    exp_t e;
    logic [31:0] w;
    logic z, n, t;
    e = '{res: 64'd0, we: 1'b1, ovf: 1'b0, unimpl: 1'b0};
    z = (a[62:0] == 63'd0);
    n = a[63] & ~z;
    t = 1'b0;
    case (f)
      11'h010: begin w = {b[63:62], b[58:29]}; e.res = {{32{w[31]}}, w}; end
      11'h030: e.res = {b[31:30], 3'b0, b[29:0], 29'b0};
      11'h130, 11'h530: begin
        e.res = {b[31:30], 3'b0, b[29:0], 29'b0};
        if (!(b[63:31] == 33'd0 || b[63:31] == {33{1'b1}})) begin
          e.ovf = 1'b1; e.we = 1'b0;
        end
      end
      11'h020: e.res = {a[63], b[62:0]};
      11'h021: e.res = {~a[63], b[62:0]};
      11'h022: e.res = {a[63:52], b[51:0]};
      11'h024: e.we = 1'b0;
      11'h025: e.res = ctl;
      11'h02a, 11'h02b, 11'h02c, 11'h02d, 11'h02e, 11'h02f: begin
        case (f[2:0])
          3'h2: t = z;
          3'h3: t = ~z;
          3'h4: t = n;
          3'h5: t = ~n;
          3'h6: t = n | z;
          default: t = ~n & ~z;
        endcase
        e.res = t ? b : c;
      end
      default: begin e.we = 1'b0; e.unimpl = 1'b1; end
    endcase
    return e;
  endfunction

  task automatic compare(string tag, exp_t exp);
    checks++;
    if (result_o !== exp.res || wr_en_o !== exp.we ||
        ovf_fault_o !== exp.ovf || unimpl_o !== exp.unimpl) begin
      fails++;
      $display("FAIL %s: got res=%h we=%b ovf=%b unimpl=%b, expected res=%h we=%b ovf=%b unimpl=%b",
               tag, result_o, wr_en_o, ovf_fault_o, unimpl_o,
               exp.res, exp.we, exp.ovf, exp.unimpl);
    end
  endtask

  task automatic run_op(logic [10:0] f, logic [63:0] a, b, c);
    exp_t e;
    e = model(f, a, b, c, ctrl_m);
    if (f == 11'h024) ctrl_m = a;
    func_i = f; op_a_i = a; op_b_i = b; op_c_i = c; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    compare(req_of(f), e);
    last_res = e.res;
  endtask

  task automatic idle_check();
    func_i = 11'h020; op_a_i = '1; op_b_i = '1;
    @(negedge clk_i);
    compare("R9", '{res: last_res, we: 1'b0, ovf: 1'b0, unimpl: 1'b0});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      summary();
      $finish;
    end
  end

  localparam logic [10:0] CODES [16] = '{11'h010, 11'h030, 11'h130, 11'h530,
    11'h020, 11'h021, 11'h022, 11'h024, 11'h025, 11'h02a, 11'h02b, 11'h02c,
    11'h02d, 11'h02e, 11'h02f, 11'h7ff};

  initial begin
    logic [63:0] ra, rb, rc;
    logic [10:0] rf;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    compare("R10", '{res: 64'd0, we: 1'b0, ovf: 1'b0, unimpl: 1'b0});
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_op(11'h025, 64'h1, 64'h2, 64'h3);                 // R7 reset value
    run_op(11'h024, 64'hDEAD_BEEF_0123_4567, '0, '0);     // R7 write
    run_op(11'h025, '0, '0, '0);                          // R7 read back
    run_op(11'h010, '0, 64'hC000_0000_2000_0000, '0);     // R1 negative
    run_op(11'h010, '0, 64'h4FFF_FFFF_E000_0000, '0);     // R1 positive
    run_op(11'h030, '0, 64'hFFFF_FFFF_FFFF_FFFF, '0);     // R2
    run_op(11'h130, '0, 64'hFFFF_FFFF_8000_0000, '0);     // R3 all ones
    run_op(11'h130, '0, 64'h0000_0000_8000_0000, '0);     // R3 fault
    run_op(11'h530, '0, 64'h0000_0000_7FFF_FFFF, '0);     // R3 all zeros
    run_op(11'h530, '0, 64'h8000_0000_0000_0000, '0);     // R3 fault
    run_op(11'h021, 64'h8000_0000_0000_0000, 64'h1234, '0); // R4
    run_op(11'h022, 64'hABC0_0000_0000_0000, '1, '0);     // R5
    for (int k = 0; k < 6; k++) begin                     // R6 both zeros
      run_op(11'h02a + 11'(k), 64'h0, 64'hB, 64'hC);
      run_op(11'h02a + 11'(k), 64'h8000_0000_0000_0000, 64'hB, 64'hC);
      run_op(11'h02a + 11'(k), 64'h8000_0000_0000_0001, 64'hB, 64'hC);
      run_op(11'h02a + 11'(k), 64'h0000_0000_0000_0001, 64'hB, 64'hC);
    end
    run_op(11'h031, 64'h5, 64'h6, 64'h7);                 // R8
    run_op(11'h7ff, 64'h5, 64'h6, 64'h7);                 // R8
    idle_check();
    idle_check();

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) rf = 11'($urandom);
      else rf = CODES[$urandom_range(15)];
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rc = {$urandom, $urandom};
      case ($urandom_range(5))
        0: ra = {ra[63], 63'd0};
        1: rb = {{33{rb[63]}}, rb[30:0]};
        default: ;
      endcase
      run_op(rf, ra, rb, rc);
      if ($urandom_range(9) == 0) idle_check();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule